// File: doc/BRIEF.md
# Cartesian Pixel Bit-Address Generator

The block maps an unsigned (x, y) pixel coordinate onto a linear bit address inside a frame buffer that stores one bit per pixel. Two values come with each request: a 32-bit origin, which is the bit address of the top-left pixel (0,0), and a 32-bit row pitch, which is the distance in bits between two vertically adjacent pixels. The address is `origin + y*pitch + x`, computed modulo 2^32. A step of one in x moves the address by one bit. A step of one in y moves it by one pitch.

In single mode the block performs one registered multiply-add for each start strobe. In fat-pixel mode one start strobe makes the block emit the four bit addresses of the 2x2 group whose top-left pixel is (x, y), one address per cycle. It forms the first address with the multiply-add. Each later address is the previous one plus an increment, so no further multiply is needed. A consumer that sets or clears the bits is attached downstream. That consumer, memory access and clipping are not part of this block.

Top module: `pixaddr_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset is released with no start, valid_o, done_o and addr_o are all 0.
- R2: In single mode (mode_i = 0), an accepted start_i makes addr_o equal origin_i + y_i*pitch_i + x_i in the next cycle. In that cycle valid_o and done_o are both 1, and the result is shown for exactly that one cycle.
- R3: All address arithmetic wraps modulo 2^32. Coordinates are 16-bit unsigned, and origin, pitch and address are 32-bit.
- R4: In fat-pixel mode (mode_i = 1), an accepted start_i makes the block emit, in four consecutive cycles starting the next cycle, the addresses of (x,y), (x+1,y), (x,y+1) and (x+1,y+1). valid_o is 1 in all four cycles.
- R5: In fat-pixel mode, done_o is 0 with the first three addresses and 1 with the fourth. done_o is never 1 while valid_o is 0.
- R6: Each fat-pixel address after the first is the previous address plus 1, then plus (pitch-1), then plus 1. The block uses the pitch captured at the accepted start, so changes to origin_i, pitch_i, x_i, y_i or mode_i during a sequence have no effect on that sequence.
- R7: A start_i in a cycle where valid_o = 1 and done_o = 0 (a fat-pixel sequence in progress) is ignored. It does not alter the sequence and produces no result after the sequence ends.
- R8: A start_i in a cycle where done_o = 1 is accepted, so a new result follows in the very next cycle with no idle gap.
- R9: After a result with done_o = 1, if no start is accepted, valid_o and done_o are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one cycle |
| mode_i | input | 1 | 0 = single pixel, 1 = 2x2 fat pixel |
| origin_i | input | 32 | Bit address of pixel (0,0) |
| pitch_i | input | 32 | Bits between vertically adjacent pixels |
| x_i | input | 16 | Pixel column |
| y_i | input | 16 | Pixel row |
| addr_o | output | 32 | Bit address result |
| valid_o | output | 1 | addr_o holds a result this cycle |
| done_o | output | 1 | Last address of the current request |

## Verification
The bench builds the block with its default widths: 16-bit coordinates and a 32-bit address. At these widths, origins close to 2^32, a pitch of all ones and coordinates of 0xFFFF all make the sums and products wrap, and the bench computes each expected value by the same modulo rule. It uses a pitch of 1 to reach the case where the (pitch-1) step adds zero, so the second and third fat-pixel addresses are equal. Directed tests cover the following:
- a start that arrives in the middle of a sequence while the input values change, to show it is ignored;
- a start in the done cycle, to show back-to-back acceptance;
- a reset asserted while a sequence is running.

// File: rtl/pixaddr_pkg.sv
package pixaddr_pkg;
  localparam int unsigned FAT_STEPS = 4;
  localparam int unsigned STEP_W    = $clog2(FAT_STEPS);

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_FAT    = 1'b1
  } mode_e;
endpackage

// File: rtl/pixaddr_mac.sv
module pixaddr_mac #(
  parameter int unsigned COORD_W = 16,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0]  origin_i,
  input  logic [ADDR_W-1:0]  pitch_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [ADDR_W-1:0]  base_o
);
  localparam int unsigned PAD_W = ADDR_W - COORD_W;

  logic [ADDR_W-1:0] x_ext, y_ext, row_off;

  always_comb begin
    x_ext   = {{PAD_W{1'b0}}, x_i};
    y_ext   = {{PAD_W{1'b0}}, y_i};
    row_off = y_ext * pitch_i;  // truncated: modulo 2^ADDR_W
    base_o  = origin_i + row_off + x_ext;
  end
endmodule

// File: rtl/pixaddr_step.sv
module pixaddr_step
  import pixaddr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] pitch_i,
  output logic [ADDR_W-1:0] inc_o
);
  // step 0 -> (x+1,y): +1 ; step 1 -> (x,y+1): +pitch-1 ; step 2 -> (x+1,y+1): +1
  always_comb begin
    if (step_i == STEP_W'(1)) inc_o = pitch_i - ADDR_W'(1);
    else                      inc_o = ADDR_W'(1);
  end
endmodule

// File: rtl/pixaddr_seq.sv
module pixaddr_seq
  import pixaddr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  output logic              accept_o,
  output logic              advance_o,
  output logic [STEP_W-1:0] step_o,
  output logic              valid_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FAT_STEPS - 1);

  logic              valid_q, done_q, fat_q;
  logic [STEP_W-1:0] step_q;
  logic              busy;

  assign busy      = valid_q & ~done_q;
  assign accept_o  = start_i & ~busy;
  assign advance_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      fat_q   <= 1'b0;
      step_q  <= '0;
    end else if (accept_o) begin
      valid_q <= 1'b1;
      fat_q   <= (mode_e'(mode_i) == MODE_FAT);
      done_q  <= (mode_e'(mode_i) == MODE_SINGLE);
      step_q  <= '0;
    end else if (busy) begin
      step_q  <= step_q + STEP_W'(1);
      done_q  <= (step_q + STEP_W'(1)) == LAST_STEP;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end
  end

  assign step_o  = step_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;

  // R5: done only with a valid result
  a_r5_done_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);
  // R5: fat sequence finishes on its last step
  a_r5_done_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fat_q) |-> (step_q == LAST_STEP));
  // R2: single result is complete at once
  a_r2_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !fat_q) |-> done_o);
  // R7: sequence keeps stepping regardless of start
  a_r7_busy_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o) |=> (valid_o && step_q == $past(step_q) + STEP_W'(1)));
  // R9: idle after completion without a start
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !valid_o);
endmodule

// File: rtl/pixaddr_gen.sv
module pixaddr_gen
  import pixaddr_pkg::*;
#(
  parameter int unsigned COORD_W = 16,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [ADDR_W-1:0]  origin_i,
  input  logic [ADDR_W-1:0]  pitch_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               valid_o,
  output logic               done_o
);
  logic              accept, advance;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] base, inc, addr_q, pitch_q;

  pixaddr_mac #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) i_mac (
    .origin_i (origin_i),
    .pitch_i  (pitch_i),
    .x_i      (x_i),
    .y_i      (y_i),
    .base_o   (base)
  );

  pixaddr_step #(.ADDR_W(ADDR_W)) i_step (
    .step_i  (step),
    .pitch_i (pitch_q),
    .inc_o   (inc)
  );

  pixaddr_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .accept_o  (accept),
    .advance_o (advance),
    .step_o    (step),
    .valid_o   (valid_o),
    .done_o    (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      pitch_q <= '0;
    end else if (accept) begin
      addr_q  <= base;
      pitch_q <= pitch_i;
    end else if (advance) begin
      addr_q  <= addr_q + inc;
    end
  end

  assign addr_o = addr_q;

  // R2: accepted start yields a result next cycle
  a_r2_result_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !(valid_o && !done_o)) |=> valid_o);
  // R6: column steps add one
  a_r6_col_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o && step != STEP_W'(1)) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));
  // R6: row step adds pitch-1 of the captured pitch
  a_r6_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o && step == STEP_W'(1)) |=>
      (addr_o == $past(addr_o) + $past(pitch_q) - ADDR_W'(1)));
  // R6: captured pitch is stable during a sequence
  a_r6_pitch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o) |=> $stable(pitch_q));
endmodule

// File: tb/test_pixaddr_gen.sv
module test_pixaddr_gen;
  localparam int unsigned CW = 16;
  localparam int unsigned AW = 32;
  localparam int unsigned NV = 9;

  typedef struct packed {
    logic          mode;
    logic [AW-1:0] org;
    logic [AW-1:0] pitch;
    logic [CW-1:0] x;
    logic [CW-1:0] y;
    logic [AW-1:0] exp;  // expected first address
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_0000, 32'h0000_0000, 16'h0000, 16'h0000, 32'h0000_0000},
    '{1'b0, 32'h0000_1000, 32'd640,       16'd5,    16'd3,    32'h0000_1785},
    '{1'b0, 32'hFFFF_FFF0, 32'h0000_0010, 16'h0020, 16'h0000, 32'h0000_0010},
    '{1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 16'h0000, 16'h0002, 32'hFFFF_FFFE},
    '{1'b0, 32'h0000_0007, 32'h0000_0001, 16'hFFFF, 16'hFFFF, 32'h0002_0005},
    '{1'b0, 32'h0000_0100, 32'h0001_0000, 16'h0001, 16'hFFFF, 32'hFFFF_0101},
    '{1'b1, 32'h0000_0000, 32'd100,       16'd10,   16'd2,    32'd210},
    '{1'b1, 32'hFFFF_FFFE, 32'h0000_0008, 16'h0001, 16'h0000, 32'hFFFF_FFFF},
    '{1'b1, 32'h0000_0050, 32'h0000_0001, 16'h0000, 16'h0000, 32'h0000_0050}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] origin_i = '0;
  logic [AW-1:0] pitch_i = '0;
  logic [CW-1:0] x_i = '0;
  logic [CW-1:0] y_i = '0;
  logic [AW-1:0] addr_o;
  logic          valid_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  pixaddr_gen i_pixaddr_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .origin_i(origin_i), .pitch_i(pitch_i), .x_i(x_i), .y_i(y_i),
    .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o)
  );

  function automatic logic [AW-1:0] ref_addr(logic [AW-1:0] org, logic [AW-1:0] p,
                                             logic [CW-1:0] x, logic [CW-1:0] y,
                                             int dx, int dy);
    logic [AW-1:0] xe, ye;
    xe = {16'b0, x} + AW'(dx);
    ye = {16'b0, y} + AW'(dy);
    return org + ye * p + xe;
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic m, logic [AW-1:0] o, logic [AW-1:0] p,
                       logic [CW-1:0] x, logic [CW-1:0] y);
    mode_i = m; origin_i = o; pitch_i = p; x_i = x; y_i = y; start_i = 1'b1;
  endtask

  // check {valid,done} plus address
  task automatic check_out(string req, logic v, logic d, logic [AW-1:0] a);
    check({req, " flags"}, AW'({valid_o, done_o}), AW'({v, d}));
    check({req, " addr"}, addr_o, a);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] o, p;
    logic [CW-1:0] x, y;
    // R1: reset state
    #12;
    check_out("R1 in reset", 1'b0, 1'b0, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1 after release", 1'b0, 1'b0, '0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      drive(v.mode, v.org, v.pitch, v.x, v.y);
      @(negedge clk_i); start_i = 1'b0;
      if (!v.mode) begin
        check_out($sformatf("R2 R3 vec%0d", i), 1'b1, 1'b1, v.exp);
      end else begin
        check_out($sformatf("R4 R3 vec%0d p0", i), 1'b1, 1'b0, v.exp);
        @(negedge clk_i);
        check_out($sformatf("R4 R6 vec%0d p1", i), 1'b1, 1'b0,
                  ref_addr(v.org, v.pitch, v.x, v.y, 1, 0));
        @(negedge clk_i);
        check_out($sformatf("R4 R6 vec%0d p2", i), 1'b1, 1'b0,
                  ref_addr(v.org, v.pitch, v.x, v.y, 0, 1));
        @(negedge clk_i);
        check_out($sformatf("R5 R6 vec%0d p3", i), 1'b1, 1'b1,
                  ref_addr(v.org, v.pitch, v.x, v.y, 1, 1));
      end
      @(negedge clk_i);
      check_out($sformatf("R9 vec%0d idle", i), 1'b0, 1'b0, addr_o);
    end

    // R7 + R6: start mid-sequence with changed inputs is ignored
    o = 32'h0000_2000; p = 32'd48; x = 16'd7; y = 16'd9;
    drive(1'b1, o, p, x, y);
    @(negedge clk_i); start_i = 1'b0;
    check_out("R7 p0", 1'b1, 1'b0, ref_addr(o, p, x, y, 0, 0));
    drive(1'b0, 32'h1234_0000, 32'd3, 16'd1, 16'd1);
    @(negedge clk_i); start_i = 1'b0;
    check_out("R7 p1", 1'b1, 1'b0, ref_addr(o, p, x, y, 1, 0));
    pitch_i = 32'd999;
    @(negedge clk_i);
    check_out("R6 captured pitch p2", 1'b1, 1'b0, ref_addr(o, p, x, y, 0, 1));
    @(negedge clk_i);
    check_out("R7 p3", 1'b1, 1'b1, ref_addr(o, p, x, y, 1, 1));
    @(negedge clk_i);
    check_out("R7 no extra result", 1'b0, 1'b0, addr_o);

    // R8: start in done cycle is taken at once
    drive(1'b1, 32'd0, 32'd16, 16'd0, 16'd0);
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    check_out("R8 last of first", 1'b1, 1'b1, 32'd17);
    drive(1'b0, 32'd100, 32'd10, 16'd3, 16'd4);
    @(negedge clk_i); start_i = 1'b0;
    check_out("R8 back-to-back single", 1'b1, 1'b1, 32'd143);
    drive(1'b0, 32'd5, 32'd2, 16'd1, 16'd1);
    @(negedge clk_i); start_i = 1'b0;
    check_out("R8 single after single", 1'b1, 1'b1, 32'd8);

    // R1: reset during a sequence
    drive(1'b1, 32'd64, 32'd8, 16'd1, 16'd1);
    @(negedge clk_i); start_i = 1'b0;
    #2 rst_ni = 1'b0;
    #1 check_out("R1 async reset", 1'b0, 1'b0, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1 stays idle", 1'b0, 1'b0, '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule